// File: doc/BRIEF.md
# Two-Phase Threshold Corner Classifier

This block sorts a die into threshold-voltage corners for each device type separately, so that the right body bias can be picked for the PMOS and for the NMOS of a memory array. It does this by timing a calibration pulse through an external long inverter chain. The chain's output arrives asynchronously and is resynchronised before it is used. A cycle counter measures the time from launch to the first rising edge at the chain's end.

A measurement has two timed phases, each launched only once the synchronised chain output reads low. In the first phase the block drives the detector chain into a reduced-supply mode with its NMOS forward-biased and its PMOS reverse-biased, so that PMOS strength sets the delay. The count gives the PMOS corner. The block then flips the detector bias and waits a programmable settle time. It then times the chain again, this time delaying the counter start by a number of cycles taken from the PMOS corner, and that count gives the NMOS corner. When both corners are known, the block updates the two body-bias selections for the array and pulses a done flag.

All thresholds, the three hold-off values and the settle time sit in configuration registers. Reset loads them with working defaults, and they can be rewritten while the block is idle.

Top module: `corner_classifier`

## Requirements
- R1: After reset, calib, busy, done, every detector mode output, both corner codes, both counts and both bias selections are 0. The defaults are 17, 8, 15 and 11 for the PMOS-high, PMOS-low, NMOS-high and NMOS-low thresholds, hold-offs of 0, 1 and 5, and a settle count of 4.
- R2: A start request seen while idle begins a measurement. calib is high for the whole of each timed phase, and the phase's counter is cleared in the launch cycle, so that counting can begin in the first calib cycle.
- R3: chain_out passes through a two-flop synchronizer. If chain_out first goes high during cycle L of a phase (cycle 0 is the first calib cycle), the count is L+2-H, floored at 0, where H is that phase's hold-off.
- R4: With count c, the PMOS code is 2'b10 (high) when c >= the PMOS-high threshold. Otherwise it is 2'b01 (low) when c <= the PMOS-low threshold, and 2'b00 (normal) in all other cases.
- R5: While the PMOS phase is pending or running, det_lowvdd, det_nfwd and det_prev are 1, and det_nrev and det_pfwd are 0.
- R6: From the end of the PMOS phase until the NMOS phase ends, det_nrev and det_pfwd are 1, and det_lowvdd, det_nfwd and det_prev are 0.
- R7: In the PMOS phase the hold-off H is 0. In the NMOS phase, H is the high, normal or low hold-off register, selected by the PMOS code.
- R8: With count c, the NMOS code is 2'b10 when c > the NMOS-high threshold. Otherwise it is 2'b01 when c < the NMOS-low threshold, and 2'b00 in all other cases.
- R9: A count that would pass 24 stops the phase at once and is reported as 25 (timeout). A timeout always classifies as high.
- R10: When done rises, pbias_sel and nbias_sel are 2'b10 (forward) for a high corner, 2'b01 (reverse) for a low corner and 2'b00 (zero) for a normal corner.
- R11: done is high for exactly one cycle, with both codes valid. A start request while busy has no effect, so no further phase is launched afterwards.
- R12: Neither phase launches while the synchronised chain output is high. Between the two phases, calib stays low for at least settle+1 cycles.
- R13: A write through cfg_we while idle replaces all configuration registers, and every later measurement uses the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request a two-phase measurement |
| chain_out | input | 1 | Asynchronous output of the inverter chain |
| cfg_we | input | 1 | Load configuration (only while idle) |
| cfg_p_hi | input | CW | PMOS high threshold (count >=) |
| cfg_p_lo | input | CW | PMOS low threshold (count <=) |
| cfg_n_hi | input | CW | NMOS high threshold (count >) |
| cfg_n_lo | input | CW | NMOS low threshold (count <) |
| cfg_dly_hi | input | DW | NMOS hold-off when PMOS is high |
| cfg_dly_nom | input | DW | NMOS hold-off when PMOS is normal |
| cfg_dly_lo | input | DW | NMOS hold-off when PMOS is low |
| cfg_settle | input | SW | Settle cycles between phases |
| calib | output | 1 | Calibration pulse into the chain |
| busy | output | 1 | Measurement in progress |
| det_lowvdd | output | 1 | Detector reduced supply |
| det_nfwd | output | 1 | Detector NMOS forward bias |
| det_nrev | output | 1 | Detector NMOS reverse bias |
| det_pfwd | output | 1 | Detector PMOS forward bias |
| det_prev | output | 1 | Detector PMOS reverse bias |
| pmos_code | output | 2 | PMOS corner code |
| nmos_code | output | 2 | NMOS corner code |
| pmos_cnt | output | CW | PMOS phase count (25 = timeout) |
| nmos_cnt | output | CW | NMOS phase count (25 = timeout) |
| done | output | 1 | One-cycle completion pulse |
| pbias_sel | output | 2 | Array PMOS body-bias selection |
| nbias_sel | output | 2 | Array NMOS body-bias selection |

## Verification
The assertions assume that chain_out is driven like a real chain. It rises once after calib goes high and falls only after calib has dropped, so the synchronised signal is low again before the next phase launches. The bench's chain model follows that rule. It raises chain_out a chosen number of cycles into each phase and lowers it on the first cycle after calib falls. The random rise times cover both early rises, inside the hold-off window, and late ones that reach the timeout. Configuration writes and start glitches happen only at points where their documented effect, or lack of it, can be seen at the ports.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    CODE_NORM = 2'b00,
    CODE_LOW  = 2'b01,
    CODE_HIGH = 2'b10
  } corner_e;

  typedef enum logic [1:0] {
    BIAS_ZERO = 2'b00,
    BIAS_REV  = 2'b01,
    BIAS_FWD  = 2'b10
  } bias_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_P_LOW, ST_P_RUN, ST_SETTLE, ST_N_LOW, ST_N_RUN, ST_DONE
  } state_e;

  function automatic bias_e bias_for(corner_e c);
    case (c)
      CODE_HIGH: return BIAS_FWD;
      CODE_LOW:  return BIAS_REV;
      default:   return BIAS_ZERO;
    endcase
  endfunction
endpackage

// File: rtl/cc_sync.sv
module cc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], din};
  end

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/cc_cfg.sv
module cc_cfg #(
  parameter int CW          = 5,
  parameter int DW          = 3,
  parameter int SW          = 8,
  parameter int P_HI_DEF    = 17,
  parameter int P_LO_DEF    = 8,
  parameter int N_HI_DEF    = 15,
  parameter int N_LO_DEF    = 11,
  parameter int DLY_HI_DEF  = 0,
  parameter int DLY_NOM_DEF = 1,
  parameter int DLY_LO_DEF  = 5,
  parameter int SETTLE_DEF  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [CW-1:0] p_hi_i,
  input  logic [CW-1:0] p_lo_i,
  input  logic [CW-1:0] n_hi_i,
  input  logic [CW-1:0] n_lo_i,
  input  logic [DW-1:0] dly_hi_i,
  input  logic [DW-1:0] dly_nom_i,
  input  logic [DW-1:0] dly_lo_i,
  input  logic [SW-1:0] settle_i,
  output logic [CW-1:0] p_hi_q,
  output logic [CW-1:0] p_lo_q,
  output logic [CW-1:0] n_hi_q,
  output logic [CW-1:0] n_lo_q,
  output logic [DW-1:0] dly_hi_q,
  output logic [DW-1:0] dly_nom_q,
  output logic [DW-1:0] dly_lo_q,
  output logic [SW-1:0] settle_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_hi_q    <= CW'(P_HI_DEF);
      p_lo_q    <= CW'(P_LO_DEF);
      n_hi_q    <= CW'(N_HI_DEF);
      n_lo_q    <= CW'(N_LO_DEF);
      dly_hi_q  <= DW'(DLY_HI_DEF);
      dly_nom_q <= DW'(DLY_NOM_DEF);
      dly_lo_q  <= DW'(DLY_LO_DEF);
      settle_q  <= SW'(SETTLE_DEF);
    end else if (load_en) begin
      p_hi_q    <= p_hi_i;
      p_lo_q    <= p_lo_i;
      n_hi_q    <= n_hi_i;
      n_lo_q    <= n_lo_i;
      dly_hi_q  <= dly_hi_i;
      dly_nom_q <= dly_nom_i;
      dly_lo_q  <= dly_lo_i;
      settle_q  <= settle_i;
    end
  end
endmodule

// File: rtl/cc_timer.sv
module cc_timer #(
  parameter int CNT_MAX = 24,
  parameter int CW      = 5,
  parameter int DW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic [DW-1:0] holdoff,
  input  logic          sync_hi,
  output logic [CW-1:0] result,
  output logic          stop
);
  localparam logic [CW-1:0] MAXV = CW'(CNT_MAX);
  localparam logic [CW-1:0] TMO  = CW'(CNT_MAX + 1);

  logic [DW-1:0] ho_q, ho_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = (ho_q >= holdoff);

  always_comb begin
    ho_d  = ho_q;
    cnt_d = cnt_q;
    if (clear) begin
      ho_d  = '0;
      cnt_d = '0;
    end else if (run) begin
      if (!cnt_en)       ho_d  = ho_q + 1'b1;
      else if (!sync_hi) cnt_d = (cnt_q == MAXV) ? TMO : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ho_q  <= '0;
      cnt_q <= '0;
    end else begin
      ho_q  <= ho_d;
      cnt_q <= cnt_d;
    end
  end

  assign stop   = run && cnt_en && (sync_hi || (cnt_q == MAXV));
  assign result = sync_hi ? cnt_q : TMO;

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TMO);

  // R7
  holdoff_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_en && !clear) |=> (cnt_q == $past(cnt_q)));

  // R3
  stop_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_en && sync_hi) |-> stop);
endmodule

// File: rtl/corner_classifier.sv
module corner_classifier #(
  parameter int CNT_MAX     = 24,
  parameter int CW          = 5,
  parameter int DW          = 3,
  parameter int SW          = 8,
  parameter int P_HI_DEF    = 17,
  parameter int P_LO_DEF    = 8,
  parameter int N_HI_DEF    = 15,
  parameter int N_LO_DEF    = 11,
  parameter int DLY_HI_DEF  = 0,
  parameter int DLY_NOM_DEF = 1,
  parameter int DLY_LO_DEF  = 5,
  parameter int SETTLE_DEF  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          chain_out,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_p_hi,
  input  logic [CW-1:0] cfg_p_lo,
  input  logic [CW-1:0] cfg_n_hi,
  input  logic [CW-1:0] cfg_n_lo,
  input  logic [DW-1:0] cfg_dly_hi,
  input  logic [DW-1:0] cfg_dly_nom,
  input  logic [DW-1:0] cfg_dly_lo,
  input  logic [SW-1:0] cfg_settle,
  output logic          calib,
  output logic          busy,
  output logic          det_lowvdd,
  output logic          det_nfwd,
  output logic          det_nrev,
  output logic          det_pfwd,
  output logic          det_prev,
  output logic [1:0]    pmos_code,
  output logic [1:0]    nmos_code,
  output logic [CW-1:0] pmos_cnt,
  output logic [CW-1:0] nmos_cnt,
  output logic          done,
  output logic [1:0]    pbias_sel,
  output logic [1:0]    nbias_sel
);
  import cc_pkg::*;

  localparam logic [CW-1:0] TMO = CW'(CNT_MAX + 1);

  logic          sync_hi;
  logic [CW-1:0] p_hi, p_lo, n_hi, n_lo;
  logic [DW-1:0] dly_hi, dly_nom, dly_lo, holdoff;
  logic [SW-1:0] settle;
  logic          t_clear, t_run, t_stop;
  logic [CW-1:0] t_result;

  state_e        state_q, state_d;
  logic [SW-1:0] wait_q, wait_d;
  corner_e       pcode_q, pcode_d, ncode_q, ncode_d;
  bias_e         pbias_q, pbias_d, nbias_q, nbias_d;
  logic [CW-1:0] pcnt_q, pcnt_d, ncnt_q, ncnt_d;
  corner_e       p_class, n_class;

  cc_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(chain_out), .dout(sync_hi)
  );

  cc_cfg #(
    .CW(CW), .DW(DW), .SW(SW),
    .P_HI_DEF(P_HI_DEF), .P_LO_DEF(P_LO_DEF),
    .N_HI_DEF(N_HI_DEF), .N_LO_DEF(N_LO_DEF),
    .DLY_HI_DEF(DLY_HI_DEF), .DLY_NOM_DEF(DLY_NOM_DEF),
    .DLY_LO_DEF(DLY_LO_DEF), .SETTLE_DEF(SETTLE_DEF)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load_en(cfg_we && (state_q == ST_IDLE)),
    .p_hi_i(cfg_p_hi), .p_lo_i(cfg_p_lo), .n_hi_i(cfg_n_hi), .n_lo_i(cfg_n_lo),
    .dly_hi_i(cfg_dly_hi), .dly_nom_i(cfg_dly_nom), .dly_lo_i(cfg_dly_lo),
    .settle_i(cfg_settle),
    .p_hi_q(p_hi), .p_lo_q(p_lo), .n_hi_q(n_hi), .n_lo_q(n_lo),
    .dly_hi_q(dly_hi), .dly_nom_q(dly_nom), .dly_lo_q(dly_lo),
    .settle_q(settle)
  );

  always_comb begin
    if (state_q != ST_N_RUN) holdoff = '0;
    else begin
      case (pcode_q)
        CODE_HIGH: holdoff = dly_hi;
        CODE_LOW:  holdoff = dly_lo;
        default:   holdoff = dly_nom;
      endcase
    end
  end

  assign t_run   = (state_q == ST_P_RUN) || (state_q == ST_N_RUN);
  assign t_clear = ((state_q == ST_P_LOW) || (state_q == ST_N_LOW)) && !sync_hi;

  cc_timer #(.CNT_MAX(CNT_MAX), .CW(CW), .DW(DW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(t_clear), .run(t_run),
    .holdoff(holdoff), .sync_hi(sync_hi), .result(t_result), .stop(t_stop)
  );

  always_comb begin
    if (t_result == TMO || t_result >= p_hi) p_class = CODE_HIGH;
    else if (t_result <= p_lo)               p_class = CODE_LOW;
    else                                     p_class = CODE_NORM;
    if (t_result == TMO || t_result > n_hi)  n_class = CODE_HIGH;
    else if (t_result < n_lo)                n_class = CODE_LOW;
    else                                     n_class = CODE_NORM;
  end

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    pcode_d = pcode_q;
    ncode_d = ncode_q;
    pcnt_d  = pcnt_q;
    ncnt_d  = ncnt_q;
    pbias_d = pbias_q;
    nbias_d = nbias_q;
    case (state_q)
      ST_IDLE:  if (start_req) state_d = ST_P_LOW;
      ST_P_LOW: if (!sync_hi) state_d = ST_P_RUN;
      ST_P_RUN: if (t_stop) begin
        state_d = ST_SETTLE;
        pcnt_d  = t_result;
        pcode_d = p_class;
        wait_d  = '0;
      end
      ST_SETTLE: begin
        wait_d = wait_q + 1'b1;
        if (({1'b0, wait_q} + 1'b1) >= {1'b0, settle}) state_d = ST_N_LOW;
      end
      ST_N_LOW: if (!sync_hi) state_d = ST_N_RUN;
      ST_N_RUN: if (t_stop) begin
        state_d = ST_DONE;
        ncnt_d  = t_result;
        ncode_d = n_class;
        pbias_d = bias_for(pcode_q);
        nbias_d = bias_for(n_class);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      pcode_q <= CODE_NORM;
      ncode_q <= CODE_NORM;
      pcnt_q  <= '0;
      ncnt_q  <= '0;
      pbias_q <= BIAS_ZERO;
      nbias_q <= BIAS_ZERO;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      pcode_q <= pcode_d;
      ncode_q <= ncode_d;
      pcnt_q  <= pcnt_d;
      ncnt_q  <= ncnt_d;
      pbias_q <= pbias_d;
      nbias_q <= nbias_d;
    end
  end

  assign calib      = t_run;
  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_DONE);
  assign det_lowvdd = (state_q == ST_P_LOW) || (state_q == ST_P_RUN);
  assign det_nfwd   = det_lowvdd;
  assign det_prev   = det_lowvdd;
  assign det_nrev   = (state_q == ST_SETTLE) || (state_q == ST_N_LOW) || (state_q == ST_N_RUN);
  assign det_pfwd   = det_nrev;
  assign pmos_code  = pcode_q;
  assign nmos_code  = ncode_q;
  assign pmos_cnt   = pcnt_q;
  assign nmos_cnt   = ncnt_q;
  assign pbias_sel  = pbias_q;
  assign nbias_sel  = nbias_q;

  // R12
  chain_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(calib) |-> !$past(sync_hi));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R5
  mode_p_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_lowvdd |-> (det_nfwd && det_prev && !det_nrev && !det_pfwd));

  // R6
  mode_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_nrev |-> (det_pfwd && !det_lowvdd && !det_nfwd && !det_prev));

  // R10
  code_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pmos_code != 2'b11 && nmos_code != 2'b11 &&
              pbias_sel != 2'b11 && nbias_sel != 2'b11));

  // R9
  timeout_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && nmos_cnt == TMO) |-> (nmos_code == 2'b10));
endmodule

// File: tb/corner_classifier_test.sv
module corner_classifier_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_req = 1'b0;
  logic       chain_out = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_p_hi = 5'd17, cfg_p_lo = 5'd8, cfg_n_hi = 5'd15, cfg_n_lo = 5'd11;
  logic [2:0] cfg_dly_hi = 3'd0, cfg_dly_nom = 3'd1, cfg_dly_lo = 3'd5;
  logic [7:0] cfg_settle = 8'd4;
  logic       calib, busy, det_lowvdd, det_nfwd, det_nrev, det_pfwd, det_prev, done;
  logic [1:0] pmos_code, nmos_code, pbias_sel, nbias_sel;
  logic [4:0] pmos_cnt, nmos_cnt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int e_phi = 17, e_plo = 8, e_nhi = 15, e_nlo = 11;
  int e_dhi = 0, e_dnom = 1, e_dlo = 5, e_settle = 4;

  always #2.5 clk = ~clk;

  corner_classifier uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .chain_out(chain_out),
    .cfg_we(cfg_we), .cfg_p_hi(cfg_p_hi), .cfg_p_lo(cfg_p_lo),
    .cfg_n_hi(cfg_n_hi), .cfg_n_lo(cfg_n_lo), .cfg_dly_hi(cfg_dly_hi),
    .cfg_dly_nom(cfg_dly_nom), .cfg_dly_lo(cfg_dly_lo), .cfg_settle(cfg_settle),
    .calib(calib), .busy(busy), .det_lowvdd(det_lowvdd), .det_nfwd(det_nfwd),
    .det_nrev(det_nrev), .det_pfwd(det_pfwd), .det_prev(det_prev),
    .pmos_code(pmos_code), .nmos_code(nmos_code), .pmos_cnt(pmos_cnt),
    .nmos_cnt(nmos_cnt), .done(done), .pbias_sel(pbias_sel), .nbias_sel(nbias_sel)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_cnt(int rise, int hold);
    int v = rise + 2 - hold;
    if (v < 0) v = 0;
    if (v > 24) v = 25;
    return v;
  endfunction

  function automatic int exp_pcode(int c);
    if (c == 25 || c >= e_phi) return 2;
    if (c <= e_plo) return 1;
    return 0;
  endfunction

  function automatic int exp_ncode(int c);
    if (c == 25 || c > e_nhi) return 2;
    if (c < e_nlo) return 1;
    return 0;
  endfunction

  function automatic int hold_for(int pc);
    if (pc == 2) return e_dhi;
    if (pc == 1) return e_dlo;
    return e_dnom;
  endfunction

  // Chain model: rises in cycle 'rise' of the phase, falls once calib drops.
  task automatic do_phase(int rise, bit nphase, bit glitch, output int gap);
    int k;
    gap = 0;
    while (!calib) begin
      @(negedge clk);
      gap++;
    end
    if (!nphase) begin
      check("R5 lowvdd", det_lowvdd, 1);
      check("R5 nfwd/prev", det_nfwd & det_prev, 1);
      check("R5 nrev/pfwd", det_nrev | det_pfwd, 0);
    end else begin
      check("R6 nrev/pfwd", det_nrev & det_pfwd, 1);
      check("R6 lowvdd/nfwd/prev", det_lowvdd | det_nfwd | det_prev, 0);
    end
    k = 0;
    while (calib) begin
      if (k == rise) chain_out = 1'b1;
      start_req = glitch && (k == 1);
      @(negedge clk);
      k++;
    end
    start_req = 1'b0;
    chain_out = 1'b0;
  endtask

  task automatic measure(int prise, int nrise, bit glitch);
    int pc, pk, nc, nk, gap;
    @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    check("R2 busy after start", busy, 1);
    do_phase(prise, 1'b0, glitch, gap);
    pc = exp_cnt(prise, 0);
    pk = exp_pcode(pc);
    do_phase(nrise, 1'b1, 1'b0, gap);
    check("R12 settle gap", (gap >= e_settle + 1) ? 1 : 0, 1);
    nc = exp_cnt(nrise, hold_for(pk));
    nk = exp_ncode(nc);
    while (!done) @(negedge clk);
    check("R3 R9 pmos count", pmos_cnt, pc);
    check("R4 pmos code", pmos_code, pk);
    check("R7 R8 nmos count", nmos_cnt, nc);
    check("R8 nmos code", nmos_code, nk);
    check("R10 pbias", pbias_sel, pk);
    check("R10 nbias", nbias_sel, nk);
    @(negedge clk);
    check("R11 done one cycle", done, 0);
    if (glitch) begin
      repeat (4) @(negedge clk);
      check("R11 start ignored while busy", calib | busy | det_lowvdd, 0);
    end
  endtask

  task automatic load_cfg(int phi, int plo, int nhi, int nlo, int dh, int dn, int dl, int st);
    @(negedge clk);
    cfg_p_hi = 5'(phi); cfg_p_lo = 5'(plo); cfg_n_hi = 5'(nhi); cfg_n_lo = 5'(nlo);
    cfg_dly_hi = 3'(dh); cfg_dly_nom = 3'(dn); cfg_dly_lo = 3'(dl); cfg_settle = 8'(st);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    e_phi = phi; e_plo = plo; e_nhi = nhi; e_nlo = nlo;
    e_dhi = dh; e_dnom = dn; e_dlo = dl; e_settle = st;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 calib/busy/done", calib | busy | done, 0);
    check("R1 modes", det_lowvdd | det_nfwd | det_nrev | det_pfwd | det_prev, 0);
    check("R1 codes", {pmos_code, nmos_code, pbias_sel, nbias_sel}, 0);
    check("R1 counts", {pmos_cnt, nmos_cnt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", busy, 0);

    // Directed: defaults, one case per PMOS corner and NMOS boundaries
    measure(20, 12, 1'b0);   // P=22 high (H=0): N=14 normal
    measure(10, 14, 1'b0);   // P=12 normal (H=1): N=15 normal boundary
    measure(6, 16, 1'b0);    // P=8 low boundary (H=5): N=13 normal
    measure(15, 9, 1'b0);    // P=17 high boundary: N=11 normal boundary
    measure(14, 8, 1'b0);    // P=16 normal: N=9 low
    measure(2, 1, 1'b0);     // P=4 low, N rises inside hold-off: 0 low
    measure(40, 40, 1'b0);   // R9 both timeouts
    measure(22, 23, 1'b0);   // R9 P=24 exact, N=25 timeout
    measure(12, 10, 1'b1);   // R11 start glitch ignored

    // R13 new configuration
    load_cfg(10, 4, 12, 6, 2, 3, 4, 9);
    measure(8, 10, 1'b0);
    measure(4, 6, 1'b0);
    measure(1, 3, 1'b0);

    for (int i = 0; i < 40; i++) begin
      if (i == 20) load_cfg(17, 8, 15, 11, 0, 1, 5, 1);
      measure(int'($urandom_range(0, 30)), int'($urandom_range(0, 30)), (i % 7) == 3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule